// File: doc/BRIEF.md
# Chainable Four-Queue Write-Port Controller

This block is the write-side control of a four-queue FIFO device. Up to eight such devices can share one write address bus. The 5-bit write address has two fields. The upper three bits name a device, and the block compares them with a strapped identity input. The lower two bits pick one of the four local queues. A queue is chosen by pulsing the address strobe on a clock edge. The block keeps a fill level for every queue. It also drives one full flag, and that flag follows only the queue that is currently chosen.

Writes arrive as a valid/ready stream with no data path here. A write happens on a rising edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low in three cases: this device is not the chosen one, the full flag has not yet moved to a newly chosen queue, or the chosen queue is full. A source may hold `wr_valid` high for as long as it likes. Nothing is consumed until `wr_ready` is high. Reads come in as plain per-queue drain pulses.

Every queue has an active-low almost-full flag on a 4-bit bus. The bus comes with an output enable, so that several devices can share one set of wires. Ownership of the bus follows one of two schemes, fixed at reset. In the addressed scheme, a strobe plus the device field of the write address decides which device drives. In the looped scheme, every device drives in turn for one cycle in each round of eight.

Top module: `wq_wport_ctl`

## Requirements
- R1: A queue choice whose address bits [4:2] differ from `dev_id` deselects the device, and `wr_ready` stays low until a matching choice is made.
- R2: Address bits [1:0] pick the queue that receives writes, where value k stands for queue k. That queue's fill level is the one reported on bit k of `afull_n`.
- R3: After a choice on edge k, `wq_full` still shows the previous queue after edge k. From edge k+1 on, it shows the new queue.
- R4: Between a choice edge and the next edge, `wr_ready` is low, so the earliest write to the new queue is on edge k+2.
- R5: `wr_ready` is low while the chosen queue holds DEPTH words, and `wq_full` is high then. A held `wr_valid` changes no fill level.
- R6: Bit k of `afull_n` is 0 exactly while queue k holds at least DEPTH-AF_OFS words, which is 13 with the default values.
- R7: A drain pulse (`rd_en` with `rd_q`=k) lowers queue k's level by one. A pulse on an empty queue is ignored.
- R8: The bus ownership scheme is taken from `flag_mode` while reset is asserted, with 0 for addressed and 1 for looped. Later changes of `flag_mode` have no effect.
- R9: In the addressed scheme, an edge with `fstr` high sets `afull_oe` for the next cycles if address bits [4:2] equal `dev_id`, and clears it otherwise. Without `fstr`, the enable holds.
- R10: In the looped scheme, a slot counter is 0 during reset and steps by one on every edge, modulo 8. `afull_oe` is high exactly while the slot equals `dev_id`.
- R11: Straight after reset, `wr_ready`, `wq_full` and `afull_oe` are 0 (in the addressed scheme) and `afull_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| dev_id | input | 3 | Strapped device identity |
| flag_mode | input | 1 | Bus ownership scheme, sampled during reset |
| wr_addr | input | 5 | Device field [4:2], queue field [1:0] |
| addr_en | input | 1 | Queue-choice strobe |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted on this edge when valid |
| rd_en | input | 1 | Drain pulse |
| rd_q | input | 2 | Queue being drained |
| fstr | input | 1 | Almost-full bus ownership strobe |
| wq_full | output | 1 | Full status of the chosen queue |
| afull_n | output | 4 | Per-queue almost-full, active low |
| afull_oe | output | 1 | Drive enable for the almost-full bus |

## Verification
Fill-level results are due one edge after the write or drain that causes them: `afull_n` and `wq_full` are read at the falling edge after that rising edge. A queue choice has two stages. The bench reads `wq_full` and `wr_ready` at the first falling edge, where it expects the previous queue and a low ready, and again one cycle later, where it expects the new queue. An ownership strobe shows on `afull_oe` after a single edge. In the looped scheme, the expected slot count starts at zero at the release of reset and goes up once per clock period before each comparison. All inputs change on falling edges, so every sample sits half a period away from the edge that produced it.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic {
    FM_ADDRESSED = 1'b0,
    FM_LOOPED    = 1'b1
  } own_mode_e;
endpackage

// File: rtl/wq_wsel.sv
module wq_wsel #(
  parameter int ID_W = 3,
  parameter int Q_W  = 2,
  localparam int ADDR_W = ID_W + Q_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              addr_en,
  output logic [Q_W-1:0]    sel_q,
  output logic              dev_sel,
  output logic              flag_ok
);
  logic id_hit;
  assign id_hit = (wr_addr[ADDR_W-1:Q_W] == dev_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      dev_sel <= 1'b0;
      flag_ok <= 1'b0;
    end else begin
      flag_ok <= !addr_en;
      if (addr_en) begin
        sel_q   <= wr_addr[Q_W-1:0];
        dev_sel <= id_hit;
      end
    end
  end

  // R4
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |=> !flag_ok);

  // R1
  foreign_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && !id_hit) |=> !dev_sel);
endmodule

// File: rtl/wq_levels.sv
module wq_levels #(
  parameter int NQ     = 4,
  parameter int DEPTH  = 16,
  parameter int AF_OFS = 3,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] wr_en,
  input  logic [NQ-1:0] rd_req,
  output logic [NQ-1:0] full_nx,
  output logic [NQ-1:0] afull_n
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] AF_LVL   = LW'(DEPTH - AF_OFS);

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [LW-1:0] lvl, lvl_nx;
    logic          dec;

    assign dec = rd_req[g] && (lvl != '0);

    always_comb begin
      lvl_nx = lvl;
      if (wr_en[g] && !dec)      lvl_nx = lvl + 1'b1;
      else if (dec && !wr_en[g]) lvl_nx = lvl - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) lvl <= '0;
      else        lvl <= lvl_nx;
    end

    assign full_nx[g] = (lvl_nx == FULL_LVL);
    assign afull_n[g] = !(lvl >= AF_LVL);

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[g] |-> (lvl != FULL_LVL));

    // R7
    empty_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req[g] && !wr_en[g] && lvl == '0) |=> (lvl == '0));
  end
endmodule

// File: rtl/wq_flagbus.sv
module wq_flagbus
  import wq_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_mode,
  input  logic [ID_W-1:0] dev_id,
  input  logic [ID_W-1:0] addr_dev,
  input  logic            fstr,
  output logic            bus_oe
);
  own_mode_e       mode_r;
  logic [ID_W-1:0] slot;
  logic            own;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= own_mode_e'(flag_mode);
      slot   <= '0;
      own    <= 1'b0;
    end else begin
      slot <= slot + 1'b1;
      if (fstr) own <= (addr_dev == dev_id);
    end
  end

  assign bus_oe = (mode_r == FM_LOOPED) ? (slot == dev_id) : own;

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_r));

  // R9
  claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == FM_ADDRESSED && fstr && addr_dev == dev_id) |=> bus_oe);

  // R10
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_r == FM_LOOPED && bus_oe) |=> !bus_oe);
endmodule

// File: rtl/wq_wport_ctl.sv
module wq_wport_ctl #(
  parameter int NQ     = 4,
  parameter int ID_W   = 3,
  parameter int DEPTH  = 16,
  parameter int AF_OFS = 3,
  localparam int Q_W    = $clog2(NQ),
  localparam int ADDR_W = ID_W + Q_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              flag_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              addr_en,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              rd_en,
  input  logic [Q_W-1:0]    rd_q,
  input  logic              fstr,
  output logic              wq_full,
  output logic [NQ-1:0]     afull_n,
  output logic              afull_oe
);
  logic [Q_W-1:0] sel_q;
  logic           dev_sel, flag_ok, full_r, wr_fire;
  logic [NQ-1:0]  wr_en, rd_req, full_nx;

  wq_wsel #(.ID_W(ID_W), .Q_W(Q_W)) u_wsel (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .wr_addr(wr_addr),
    .addr_en(addr_en), .sel_q(sel_q), .dev_sel(dev_sel), .flag_ok(flag_ok)
  );

  assign wr_fire = wr_valid && wr_ready;

  for (genvar g = 0; g < NQ; g++) begin : g_en
    assign wr_en[g]  = wr_fire && (sel_q == Q_W'(g));
    assign rd_req[g] = rd_en && (rd_q == Q_W'(g));
  end

  wq_levels #(.NQ(NQ), .DEPTH(DEPTH), .AF_OFS(AF_OFS)) u_levels (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
    .full_nx(full_nx), .afull_n(afull_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) full_r <= 1'b0;
    else        full_r <= full_nx[sel_q];
  end

  assign wq_full  = full_r;
  assign wr_ready = dev_sel && flag_ok && !full_r;

  wq_flagbus #(.ID_W(ID_W)) u_flagbus (
    .clk(clk), .rst_n(rst_n), .flag_mode(flag_mode), .dev_id(dev_id),
    .addr_dev(wr_addr[ADDR_W-1:Q_W]), .fstr(fstr), .bus_oe(afull_oe)
  );

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wq_full |-> !wr_fire);
endmodule

// File: tb/wq_wport_ctl_bench.sv
module wq_wport_ctl_bench;
  localparam int DEPTH = 16;
  localparam int AFL   = 13;
  localparam logic [2:0] MY_ID = 3'd5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_mode = 1'b0;
  logic [4:0] wr_addr = '0;
  logic       addr_en = 1'b0, wr_valid = 1'b0, rd_en = 1'b0, fstr = 1'b0;
  logic [1:0] rd_q = '0;
  logic       wr_ready, wq_full, afull_oe;
  logic [3:0] afull_n;

  int n_run = 0, n_fail = 0;
  int cnt[4];
  int cur = 0;
  bit matched = 1'b0;

  always #10 clk = ~clk;

  wq_wport_ctl u_wq_wport_ctl (
    .clk(clk), .rst_n(rst_n), .dev_id(MY_ID), .flag_mode(flag_mode),
    .wr_addr(wr_addr), .addr_en(addr_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_en(rd_en), .rd_q(rd_q), .fstr(fstr),
    .wq_full(wq_full), .afull_n(afull_n), .afull_oe(afull_oe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_afn();
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = !(cnt[i] >= AFL);
    return v;
  endfunction

  task automatic do_reset(logic mode);
    rst_n = 1'b0; flag_mode = mode;
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    cur = 0; matched = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    check("R11 wr_ready", wr_ready, 0);
    check("R11 wq_full", wq_full, 0);
    check("R11 afull_n", afull_n, 4'hF);
    if (!mode) check("R11 afull_oe", afull_oe, 0);
    flag_mode = !mode;
  endtask

  task automatic choose(logic [2:0] id, int q);
    int old = cur;
    wr_addr = {id, 2'(q)}; addr_en = 1'b1;
    tick();
    addr_en = 1'b0;
    cur = q; matched = (id == MY_ID);
    check("R4 ready gap", wr_ready, 0);
    check("R3 old flag", wq_full, cnt[old] == DEPTH);
    tick();
    check("R3 new flag", wq_full, cnt[cur] == DEPTH);
    check("R1 ready", wr_ready, matched && cnt[cur] < DEPTH);
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      bit er = matched && cnt[cur] < DEPTH;
      check("R5 ready", wr_ready, er);
      wr_valid = 1'b1;
      if (er) cnt[cur]++;
      tick();
      check("R6 R2 afull_n", afull_n, exp_afn());
      check("R5 full", wq_full, cnt[cur] == DEPTH);
    end
    wr_valid = 1'b0;
  endtask

  task automatic drain(int q, int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1; rd_q = 2'(q);
      if (cnt[q] > 0) cnt[q]--;
      tick();
      check("R7 afull_n", afull_n, exp_afn());
      check("R7 full", wq_full, cnt[cur] == DEPTH);
    end
    rd_en = 1'b0;
  endtask

  task automatic claim(logic [2:0] id, bit strobe);
    wr_addr = {id, 2'b00}; fstr = strobe;
    tick();
    fstr = 1'b0;
  endtask

  task automatic t_foreign();
    choose(3'd2, 0);
    push(3);
    check("R1 afull_n", afull_n, 4'hF);
  endtask

  task automatic t_fill();
    choose(MY_ID, 2);
    push(12);
    check("R6 below", afull_n, 4'hF);
    push(1);
    check("R6 R2 at threshold", afull_n, 4'b1011);
    push(5);
    check("R5 capped full", wq_full, 1);
  endtask

  task automatic t_switch();
    choose(MY_ID, 1);
    choose(MY_ID, 2);
    check("R3 back on full queue", wq_full, 1);
  endtask

  task automatic t_drain();
    drain(2, 3);
    check("R7 still high", afull_n[2], 0);
    drain(2, 1);
    check("R7 below", afull_n[2], 1);
    drain(0, 3);
    choose(MY_ID, 0);
    push(13);
    check("R7 no underflow", afull_n[0], 0);
  endtask

  task automatic t_addressed();
    claim(MY_ID, 1'b1);
    check("R9 claim", afull_oe, 1);
    claim(3'd3, 1'b0);
    check("R9 hold", afull_oe, 1);
    claim(3'd3, 1'b1);
    check("R9 release", afull_oe, 0);
    claim(MY_ID, 1'b1);
    check("R9 reclaim", afull_oe, 1);
  endtask

  task automatic t_looped();
    int slot = 0;
    do_reset(1'b1);
    for (int i = 0; i < 16; i++) begin
      tick();
      slot = (slot + 1) % 8;
      check("R10 R8 slot enable", afull_oe, slot == int'(MY_ID));
    end
  endtask

  initial begin
    do_reset(1'b0);
    t_foreign();
    t_fill();
    t_switch();
    t_drain();
    t_addressed();
    t_looped();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule